// File: doc/BRIEF.md
# Load/Store Overtake Permission Checker

This block sits beside a small, strictly ordered queue of memory operations that have issued but not yet completed. When a newer memory operation is ready to go, the block compares it against every operation still held. It returns a registered verdict: either the newcomer may overtake all of them, or it is held back, together with the queue slot of the blocking operation.

The verdict depends on the operation kinds and on the memory attributes of both sides, not only on address equality. Loads may pass loads, and stores may pass stores, only in plain cacheable memory; a store never passes a load. A load may pass a store only once that store's exception check has completed and only if their bytes do not touch. Overlap is detected by matching the 8-byte doubleword address and ANDing the byte-enable masks. The queue fills in program order, retires from its oldest end and accepts a per-slot notice that an entry's exception check is done.

Top module: `bq_order_check`

## Requirements
- R1: After synchronous reset the queue is empty, and `res_vld`, `allow`, `blk_vld` and `blk_idx` are 0; a request against the empty queue is allowed.
- R2: `enq` appends an entry at the young end, in slots 0,1,2,... wrapping modulo DEPTH (a power of two). `retire` removes the oldest entry. An `enq` when DEPTH entries are held at the start of the cycle is ignored, even with a simultaneous `retire`. A `retire` on an empty queue is ignored.
- R3: A request presented with `req_vld` in cycle n yields `res_vld`=1 in cycle n+1, judged against the queue contents before cycle n's enq, retire and check updates. Without a request, `res_vld`, `allow`, `blk_vld` and `blk_idx` are 0 in the next cycle.
- R4: A load (`req_st`=0) is blocked by an older store whose exception-checked flag is clear. `chk_vld` with `chk_idx` sets that flag for a valid slot; a new entry starts with the flag clear.
- R5: A load is blocked by an older store whose bytes overlap it, even when that store is checked. Overlap means equal address bits above bit 2 and a non-zero AND of the two 8-bit byte-enable masks.
- R6: A load may pass an older load only when neither is guarded (`g`) or caching-inhibited (`ci`).
- R7: A store (`req_st`=1) may pass an older store only when neither is guarded, caching-inhibited or write-through (`wt`) and their bytes do not overlap.
- R8: A store is always blocked by any older load in the queue.
- R9: In a load-versus-older-store pairing, a guarded or caching-inhibited flag on either side blocks, even with the store checked and no overlap.
- R10: `allow`=1 exactly when no held entry blocks; otherwise `blk_vld`=1 and `blk_idx` is the slot of the youngest blocking entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq | input | 1 | Append an operation to the queue |
| enq_st | input | 1 | Appended operation is a store (0 = load) |
| enq_addr | input | ADDR_W | Byte address of appended operation |
| enq_be | input | BE_W | Byte-enable mask of appended operation |
| enq_g | input | 1 | Appended operation is guarded |
| enq_ci | input | 1 | Appended operation is caching-inhibited |
| enq_wt | input | 1 | Appended operation is write-through |
| retire | input | 1 | Remove the oldest entry |
| chk_vld | input | 1 | Mark an entry's exception check done |
| chk_idx | input | IDX_W | Slot whose check is done |
| req_vld | input | 1 | A newer operation asks to overtake |
| req_st | input | 1 | Request is a store (0 = load) |
| req_addr | input | ADDR_W | Request byte address |
| req_be | input | BE_W | Request byte-enable mask |
| req_g | input | 1 | Request is guarded |
| req_ci | input | 1 | Request is caching-inhibited |
| req_wt | input | 1 | Request is write-through |
| res_vld | output | 1 | Verdict valid (one cycle after request) |
| allow | output | 1 | Request may overtake all held entries |
| blk_vld | output | 1 | A held entry blocks the request |
| blk_idx | output | IDX_W | Slot of the youngest blocking entry |

## Verification
Directed sequences set up each pairing in turn: load behind an unchecked then checked store, loads at the same doubleword with disjoint and shared byte lanes, load pairs and store pairs with each attribute flag set on one side, and a store behind a load. Each tells one rule apart from the neighbouring ones. A queue held full and then drained with wrap-around shows that slot numbering and youngest-first reporting follow age rather than slot order. Long random runs mix simultaneous enqueue, retire, check and request over a few doublewords so that several blockers coexist, and every verdict is compared with a behavioural model.

// File: rtl/bq_pkg.sv
package bq_pkg;
  // Memory attributes carried with each operation
  typedef struct packed {
    logic g;   // guarded
    logic ci;  // caching-inhibited
    logic wt;  // write-through
  } attr_t;
endpackage

// File: rtl/bq_queue.sv
module bq_queue
  import bq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq,
  input  logic              enq_st,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [BE_W-1:0]   enq_be,
  input  attr_t             enq_attr,
  input  logic              retire,
  input  logic              chk_vld,
  input  logic [IDX_W-1:0]  chk_idx,
  output logic [DEPTH-1:0]  vld_o,
  output logic [DEPTH-1:0]  st_o,
  output logic [DEPTH-1:0]  chk_o,
  output logic [ADDR_W-1:0] addr_o [DEPTH],
  output logic [BE_W-1:0]   be_o   [DEPTH],
  output attr_t             attr_o [DEPTH],
  output logic [IDX_W-1:0]  head_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              has_ld_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             do_enq, do_ret;
  logic [IDX_W-1:0] tail;

  assign do_enq   = enq && (cnt_o != FULL);
  assign do_ret   = retire && (cnt_o != '0);
  assign tail     = head_o + cnt_o[IDX_W-1:0];
  assign has_ld_o = |(vld_o & ~st_o);

  // Payload: written on enqueue only, no reset needed
  always_ff @(posedge clk) begin
    if (do_enq) begin
      st_o[tail]   <= enq_st;
      addr_o[tail] <= enq_addr;
      be_o[tail]   <= enq_be;
      attr_o[tail] <= enq_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= '0;
      chk_o  <= '0;
      head_o <= '0;
      cnt_o  <= '0;
    end else begin
      if (chk_vld && vld_o[chk_idx]) chk_o[chk_idx] <= 1'b1;
      if (do_enq) begin
        vld_o[tail] <= 1'b1;
        chk_o[tail] <= 1'b0;
      end
      if (do_ret) begin
        vld_o[head_o] <= 1'b0;
        head_o        <= head_o + 1'b1;
      end
      case ({do_enq, do_ret})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  // R2: occupancy never exceeds the queue size
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= FULL);
  // R2: an enqueue into a full queue without retire leaves it full
  p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == FULL) && enq && !retire |=> cnt_o == FULL);
  // R2: retire from a non-empty queue without enqueue shrinks it by one
  p_ret_dec_r2: assert property (@(posedge clk) disable iff (rst)
    retire && !enq && (cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
endmodule

// File: rtl/bq_rule.sv
module bq_rule
  import bq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8,
  localparam int LANE_W = $clog2(BE_W)
) (
  input  logic              e_vld,
  input  logic              e_st,
  input  logic              e_chk,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [BE_W-1:0]   e_be,
  input  attr_t             e_attr,
  input  logic              r_st,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [BE_W-1:0]   r_be,
  input  attr_t             r_attr,
  output logic              conflict
);
  logic ovl, risky, block;

  assign ovl   = (e_addr[ADDR_W-1:LANE_W] == r_addr[ADDR_W-1:LANE_W]) && |(e_be & r_be);
  assign risky = e_attr.g | e_attr.ci | r_attr.g | r_attr.ci;

  always_comb begin
    case ({r_st, e_st})
      2'b00:   block = risky;                               // load over load
      2'b01:   block = risky | ~e_chk | ovl;                // load over store
      2'b10:   block = 1'b1;                                // store over load
      default: block = risky | e_attr.wt | r_attr.wt | ovl; // store over store
    endcase
  end

  assign conflict = e_vld & block;
endmodule

// File: rtl/bq_pick.sv
module bq_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] conf,
  input  logic [IDX_W-1:0] head,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Walk from oldest to youngest; the last hit is the youngest blocker
  always_comb begin
    idx = '0;
    for (int a = 0; a < DEPTH; a++) begin
      if (conf[head + IDX_W'(a)]) idx = head + IDX_W'(a);
    end
  end
  assign any = |conf;
endmodule

// File: rtl/bq_order_check.sv
module bq_order_check
  import bq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq,
  input  logic              enq_st,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [BE_W-1:0]   enq_be,
  input  logic              enq_g,
  input  logic              enq_ci,
  input  logic              enq_wt,
  input  logic              retire,
  input  logic              chk_vld,
  input  logic [IDX_W-1:0]  chk_idx,
  input  logic              req_vld,
  input  logic              req_st,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_g,
  input  logic              req_ci,
  input  logic              req_wt,
  output logic              res_vld,
  output logic              allow,
  output logic              blk_vld,
  output logic [IDX_W-1:0]  blk_idx
);
  logic [DEPTH-1:0]  q_vld, q_st, q_chk, conf;
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [BE_W-1:0]   q_be   [DEPTH];
  attr_t             q_attr [DEPTH];
  logic [IDX_W-1:0]  head, pick_idx;
  logic [CNT_W-1:0]  cnt;
  logic              has_ld, any;
  attr_t             enq_attr, req_attr;

  assign enq_attr = '{g: enq_g, ci: enq_ci, wt: enq_wt};
  assign req_attr = '{g: req_g, ci: req_ci, wt: req_wt};

  bq_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_queue (
    .clk(clk), .rst(rst),
    .enq(enq), .enq_st(enq_st), .enq_addr(enq_addr), .enq_be(enq_be), .enq_attr(enq_attr),
    .retire(retire), .chk_vld(chk_vld), .chk_idx(chk_idx),
    .vld_o(q_vld), .st_o(q_st), .chk_o(q_chk), .addr_o(q_addr), .be_o(q_be),
    .attr_o(q_attr), .head_o(head), .cnt_o(cnt), .has_ld_o(has_ld)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_rule
    bq_rule #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_rule (
      .e_vld(q_vld[i]), .e_st(q_st[i]), .e_chk(q_chk[i]), .e_addr(q_addr[i]),
      .e_be(q_be[i]), .e_attr(q_attr[i]),
      .r_st(req_st), .r_addr(req_addr), .r_be(req_be), .r_attr(req_attr),
      .conflict(conf[i])
    );
  end

  bq_pick #(.DEPTH(DEPTH)) u_pick (.conf(conf), .head(head), .any(any), .idx(pick_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      allow   <= 1'b0;
      blk_vld <= 1'b0;
      blk_idx <= '0;
    end else begin
      res_vld <= req_vld;
      allow   <= req_vld & ~any;
      blk_vld <= req_vld & any;
      blk_idx <= req_vld ? pick_idx : '0;
    end
  end

  // R8: a store request with any held load is refused
  p_st_after_ld_r8: assert property (@(posedge clk) disable iff (rst)
    req_vld && req_st && has_ld |=> !allow && blk_vld);
  // R1: the empty queue lets every request through
  p_empty_pass_r1: assert property (@(posedge clk) disable iff (rst)
    req_vld && (cnt == '0) |=> allow && !blk_vld);
  // R3: no request, no verdict
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !res_vld && !allow && !blk_vld);
  // R10: a reported blocker names a slot that held an entry
  p_blk_live_r10: assert property (@(posedge clk) disable iff (rst)
    req_vld && any |-> q_vld[pick_idx]);
endmodule

// File: tb/sim_bq_order_check.sv
`timescale 1ns/1ps
module sim_bq_order_check;
  localparam int D = 8, AW = 32, BW = 8, IW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, enq, enq_st, enq_g, enq_ci, enq_wt, retire, chk_vld;
  logic req_vld, req_st, req_g, req_ci, req_wt;
  logic [AW-1:0] enq_addr, req_addr;
  logic [BW-1:0] enq_be, req_be;
  logic [IW-1:0] chk_idx, blk_idx;
  logic res_vld, allow, blk_vld;

  bq_order_check #(.DEPTH(D), .ADDR_W(AW), .BE_W(BW)) u0 (
    .clk(clk), .rst(rst), .enq(enq), .enq_st(enq_st), .enq_addr(enq_addr), .enq_be(enq_be),
    .enq_g(enq_g), .enq_ci(enq_ci), .enq_wt(enq_wt), .retire(retire),
    .chk_vld(chk_vld), .chk_idx(chk_idx), .req_vld(req_vld), .req_st(req_st),
    .req_addr(req_addr), .req_be(req_be), .req_g(req_g), .req_ci(req_ci), .req_wt(req_wt),
    .res_vld(res_vld), .allow(allow), .blk_vld(blk_vld), .blk_idx(blk_idx)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit finished = 0;

  // Behavioural model: plain arrays indexed by slot
  bit m_v[D], m_s[D], m_g[D], m_ci[D], m_wt[D], m_c[D];
  logic [AW-1:0] m_a[D];
  logic [BW-1:0] m_b[D];
  int m_head = 0, m_n = 0;
  bit e_res, e_allow, e_blk;
  int e_idx;

  function automatic bit blocks(int s);
    bit same, bad;
    if (!m_v[s]) return 0;
    same = (m_a[s][AW-1:3] == req_addr[AW-1:3]) && ((m_b[s] & req_be) != 0);
    bad  = m_g[s] || m_ci[s] || req_g || req_ci;
    if (!req_st && !m_s[s]) return bad;                          // R6
    if (!req_st &&  m_s[s]) return bad || !m_c[s] || same;       // R4 R5 R9
    if ( req_st && !m_s[s]) return 1;                            // R8
    return bad || m_wt[s] || req_wt || same;                     // R7
  endfunction

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst) begin
      e_res = 0; e_allow = 0; e_blk = 0; e_idx = 0;
      foreach (m_v[i]) begin m_v[i] = 0; m_c[i] = 0; end
      m_head = 0; m_n = 0;
    end else begin
      int n0;
      e_res = req_vld; e_allow = 0; e_blk = 0; e_idx = 0;
      if (req_vld) begin
        for (int a = 0; a < m_n; a++) begin
          int s = (m_head + a) % D;
          if (blocks(s)) begin e_blk = 1; e_idx = s; end
        end
        e_allow = !e_blk;
      end
      n0 = m_n;
      if (chk_vld && m_v[chk_idx]) m_c[chk_idx] = 1;
      if (enq && n0 < D) begin
        int t = (m_head + n0) % D;
        m_v[t] = 1; m_c[t] = 0; m_s[t] = enq_st; m_a[t] = enq_addr; m_b[t] = enq_be;
        m_g[t] = enq_g; m_ci[t] = enq_ci; m_wt[t] = enq_wt;
        m_n++;
      end
      if (retire && n0 > 0) begin
        m_v[m_head] = 0; m_head = (m_head + 1) % D; m_n--;
      end
    end
    @(negedge clk);
    check("res_vld", res_vld, e_res);
    check("allow", allow, e_allow);
    check("blk_vld", blk_vld, e_blk);
    check("blk_idx", blk_idx, e_idx);
  endtask

  task automatic idle();
    enq = 0; retire = 0; chk_vld = 0; req_vld = 0;
  endtask

  task automatic push(bit st, logic [AW-1:0] a, logic [BW-1:0] b, bit g, bit ci, bit wt);
    enq = 1; enq_st = st; enq_addr = a; enq_be = b; enq_g = g; enq_ci = ci; enq_wt = wt;
    cyc(); idle();
  endtask

  task automatic ask(bit st, logic [AW-1:0] a, logic [BW-1:0] b, bit g, bit ci, bit wt);
    req_vld = 1; req_st = st; req_addr = a; req_be = b; req_g = g; req_ci = ci; req_wt = wt;
    cyc(); idle();
  endtask

  task automatic mark(int s);
    chk_vld = 1; chk_idx = IW'(s); cyc(); idle();
  endtask

  task automatic drain();
    retire = 1; repeat (D + 1) cyc(); idle();
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    enq_st = 0; enq_addr = 0; enq_be = 0; enq_g = 0; enq_ci = 0; enq_wt = 0;
    req_st = 0; req_addr = 0; req_be = 0; req_g = 0; req_ci = 0; req_wt = 0; chk_idx = 0;
    rst = 1;
    repeat (3) cyc();                      // R1 reset state
    rst = 0;
    tag = "R1"; ask(0, 32'h40, 8'hFF, 0, 0, 0);   // empty queue: allowed
    tag = "R3"; cyc();                            // idle cycle, quiet outputs

    tag = "R4";                                   // load behind unchecked, then checked store
    push(1, 32'h100, 8'h0F, 0, 0, 0);
    ask(0, 32'h200, 8'hFF, 0, 0, 0);
    mark(0);
    ask(0, 32'h200, 8'hFF, 0, 0, 0);
    tag = "R5";                                   // same doubleword, disjoint then shared lanes
    ask(0, 32'h104, 8'hF0, 0, 0, 0);
    ask(0, 32'h100, 8'h01, 0, 0, 0);
    tag = "R9";
    ask(0, 32'h200, 8'hFF, 1, 0, 0);
    ask(0, 32'h200, 8'hFF, 0, 1, 0);
    tag = "R8"; push(0, 32'h300, 8'hFF, 0, 0, 0);
    ask(1, 32'h500, 8'hFF, 0, 0, 0);
    drain();

    tag = "R6";
    push(0, 32'h10, 8'hFF, 0, 0, 0);
    ask(0, 32'h10, 8'hFF, 0, 0, 0);
    ask(0, 32'h20, 8'hFF, 1, 0, 0);
    ask(0, 32'h20, 8'hFF, 0, 1, 0);
    push(0, 32'h18, 8'hFF, 0, 1, 0);
    ask(0, 32'h20, 8'hFF, 0, 0, 0);
    drain();

    tag = "R7";
    push(1, 32'h80, 8'h0F, 0, 0, 0);
    ask(1, 32'h80, 8'hF0, 0, 0, 0);
    ask(1, 32'h80, 8'h18, 0, 0, 0);
    ask(1, 32'h90, 8'hFF, 0, 0, 1);
    ask(1, 32'h90, 8'hFF, 1, 0, 0);
    push(1, 32'hA0, 8'hFF, 0, 0, 1);
    ask(1, 32'hB0, 8'hFF, 0, 0, 0);
    drain();

    tag = "R2";                                   // fill, overfill, wrap
    for (int k = 0; k < D; k++) push(1, 32'(k * 8), 8'hFF, 0, 0, 0);
    push(0, 32'h1000, 8'hFF, 0, 0, 0);           // ignored: full
    enq = 1; retire = 1; enq_st = 0; enq_addr = 32'h1000; cyc(); idle();  // enq ignored
    ask(1, 32'h2000, 8'hFF, 0, 0, 0);
    retire = 1; repeat (3) cyc(); idle();        // retire is oldest-first
    retire = 1; enq = 1; enq_st = 1; enq_addr = 32'h38; enq_be = 8'h01; cyc(); idle();
    tag = "R10";
    for (int k = 0; k < 4; k++) mark((k + 4) % D);
    ask(0, 32'h38, 8'h01, 0, 0, 0);               // youngest overlapping store after wrap
    ask(0, 32'h20, 8'hFF, 0, 0, 0);
    drain();
    retire = 1; cyc(); idle();                    // R2 retire on empty ignored
    tag = "R2"; ask(1, 32'h0, 8'hFF, 0, 0, 0);

    tag = "R10";                                  // random mixed traffic
    for (int k = 0; k < 4000; k++) begin
      enq = ($urandom % 3) != 0; retire = ($urandom % 3) == 0;
      chk_vld = ($urandom % 2) != 0; chk_idx = IW'($urandom % D);
      req_vld = ($urandom % 4) != 0;
      enq_st = 1'($urandom); enq_addr = 32'((($urandom % 3) << 3) | ($urandom % 8));
      enq_be = BW'(($urandom % 255) + 1);
      enq_g = ($urandom % 10) == 0; enq_ci = ($urandom % 10) == 0; enq_wt = ($urandom % 8) == 0;
      req_st = 1'($urandom); req_addr = 32'((($urandom % 3) << 3) | ($urandom % 8));
      req_be = BW'(($urandom % 255) + 1);
      req_g = ($urandom % 10) == 0; req_ci = ($urandom % 10) == 0; req_wt = ($urandom % 8) == 0;
      cyc();
    end
    idle(); cyc();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule